// File: doc/BRIEF.md
# Fetch Next-PC Prediction Unit

This block picks the instruction fetch address every cycle in a five-stage in-order pipeline. It guesses the next address from the class of the instruction being fetched now. Ordinary instructions and returns continue at the sequential address. Unconditional jumps, calls and conditional jumps continue at the constant target carried in the instruction, so conditional branches are always guessed as taken. No guess is made for a return: fetch stalls until the return address comes back from the write-back stage.

Later stages report what they find. A conditional jump that reaches the memory stage with its taken flag clear was guessed wrong. The block then sends fetch to the fall-through address that the jump carried down the pipeline, and it cancels the two wrong-path instructions in the same cycle by requesting bubbles for the decode and execute pipeline registers. A return in write-back supplies its loaded address as the fetch address. While a return sits in decode, execute or memory, the predicted-PC register holds its value and decode receives bubbles.

Top module: `fetch_pc_ctrl`

## Requirements
- R1: While `rst_n` is low, `dec_bubble`, `exe_bubble` and `fetch_stall` are 0, and at the first clock edge after reset the predicted-PC register `pred_pc` holds 0.
- R2: When fetch is not stalled and `f_cls` is 0 (plain), 4 (return) or an unused code (5 to 7), `pred_pc` takes `f_nextseq` at the next clock edge.
- R3: When fetch is not stalled and `f_cls` is 1 (unconditional jump) or 2 (call), `pred_pc` takes `f_target` at the next clock edge.
- R4: When fetch is not stalled and `f_cls` is 3 (conditional jump), `pred_pc` takes `f_target` at the next clock edge (always-taken guess).
- R5: When `m_cjump` is 1 and `m_taken` is 0, `fetch_pc` equals `m_fallthru` in that same cycle.
- R6: In a mispredict cycle, `dec_bubble` and `exe_bubble` are both 1 and `fetch_stall` is 0, even if a return is in decode or execute.
- R7: When any of `d_ret`, `e_ret`, `m_ret` is 1 and there is no mispredict, `fetch_stall` and `dec_bubble` are 1, `exe_bubble` is 0, and `pred_pc` keeps its value across the next clock edge.
- R8: When `w_ret` is 1 and there is no mispredict, `fetch_pc` equals `w_retaddr` in that same cycle.
- R9: Fetch address priority: a mispredict fall-through address first, then the write-back return address, then `pred_pc`.
- R10: A conditional jump in memory with `m_taken` set causes no redirect, no bubble and no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| f_cls | input | 3 | Class of the instruction fetched this cycle (0 plain, 1 jump, 2 call, 3 conditional jump, 4 return) |
| f_nextseq | input | ADDR_W | Address following the fetched instruction |
| f_target | input | ADDR_W | Constant target held in the fetched instruction |
| d_ret | input | 1 | A return is in decode |
| e_ret | input | 1 | A return is in execute |
| m_ret | input | 1 | A return is in memory |
| m_cjump | input | 1 | A conditional jump is in memory |
| m_taken | input | 1 | Resolved taken flag of that jump |
| m_fallthru | input | ADDR_W | Fall-through address carried by that jump |
| w_ret | input | 1 | A return is in write-back |
| w_retaddr | input | ADDR_W | Return address loaded by that return |
| fetch_pc | output | ADDR_W | Address to fetch this cycle |
| pred_pc | output | ADDR_W | Predicted-PC register |
| dec_bubble | output | 1 | Load a bubble into the decode pipeline register |
| exe_bubble | output | 1 | Load a bubble into the execute pipeline register |
| fetch_stall | output | 1 | Hold the predicted-PC register and refetch |

## Verification
The bench walks straight-line code, an unconditional jump, a call, a taken and a not-taken conditional jump, and a return that passes decode, execute, memory and write-back, then forces a mispredict and a write-back return into the same cycle. A design with the wrong priority would fetch the loaded return address instead of the fall-through address. A design that let a wrong-path return in decode stall fetch during a mispredict would refetch the stale address, and one that advanced the register during a pending return would skip the stalled address. Every cycle the monitor compares all five outputs against the scoreboard, so a squash lasting a cycle too long or too short shows up at once.

// File: rtl/fpc_pkg.sv
// Shared types for the fetch next-PC unit.
// Assumes the decoder classifies each fetched instruction into one of these codes.
package fpc_pkg;
    localparam int CLS_W = 3;

    typedef enum logic [CLS_W-1:0] {
        CLS_PLAIN = 3'd0,
        CLS_JUMP  = 3'd1,
        CLS_CALL  = 3'd2,
        CLS_CJUMP = 3'd3,
        CLS_RET   = 3'd4
    } fcls_e;
endpackage

// File: rtl/fpc_predict.sv
// Static guess of the next fetch address from the class of the fetched instruction.
// Assumes nextseq and target belong to the instruction at the current fetch address.
// Returns take the sequential address as a placeholder; fetch stalls behind them.
module fpc_predict
    import fpc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [CLS_W-1:0]  cls,
    input  logic [ADDR_W-1:0] nextseq,
    input  logic [ADDR_W-1:0] target,
    output logic [ADDR_W-1:0] guess
);
    // Choose target for control transfers, sequential address otherwise.
    always_comb begin
        case (fcls_e'(cls))
            CLS_JUMP, CLS_CALL, CLS_CJUMP: guess = target;
            default:                       guess = nextseq;
        endcase
    end
endmodule

// File: rtl/fpc_select.sv
// Fixed-priority fetch address selection.
// Assumes at most one of the two repair sources is meaningful per design intent;
// if both are active the mispredict repair wins.
module fpc_select #(
    parameter int ADDR_W = 32
) (
    input  logic              mispred,
    input  logic [ADDR_W-1:0] fall_pc,
    input  logic              ret_wb,
    input  logic [ADDR_W-1:0] ret_pc,
    input  logic [ADDR_W-1:0] pred,
    output logic [ADDR_W-1:0] fetch_pc
);
    // Priority mux: mispredict repair, then return address, then prediction.
    always_comb begin
        if (mispred)     fetch_pc = fall_pc;
        else if (ret_wb) fetch_pc = ret_pc;
        else             fetch_pc = pred;
    end
endmodule

// File: rtl/fpc_hazard.sv
// Control hazard detection: mispredict squash and return stall requests.
// Assumes a mispredict kills any return younger than the jump, so it overrides the stall.
// All requests are forced low while reset is asserted.
module fpc_hazard (
    input  logic rst_n,
    input  logic d_ret,
    input  logic e_ret,
    input  logic m_ret,
    input  logic m_cjump,
    input  logic m_taken,
    output logic mispred,
    output logic dec_bubble,
    output logic exe_bubble,
    output logic fetch_stall
);
    logic ret_busy;

    // Derive mispredict and return-pending conditions, then the requests.
    always_comb begin
        mispred     = rst_n && m_cjump && !m_taken;
        ret_busy    = rst_n && (d_ret || e_ret || m_ret);
        fetch_stall = ret_busy && !mispred;
        dec_bubble  = mispred || ret_busy;
        exe_bubble  = mispred;
    end
endmodule

// File: rtl/fetch_pc_ctrl.sv
// Top of the fetch next-PC unit: holds the predicted-PC register and wires
// prediction, selection and hazard logic together.
// Assumes instruction memory is read combinationally at fetch_pc, so f_cls,
// f_nextseq and f_target describe the instruction at fetch_pc in the same cycle.
module fetch_pc_ctrl
    import fpc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        f_cls,
    input  logic [ADDR_W-1:0] f_nextseq,
    input  logic [ADDR_W-1:0] f_target,
    input  logic              d_ret,
    input  logic              e_ret,
    input  logic              m_ret,
    input  logic              m_cjump,
    input  logic              m_taken,
    input  logic [ADDR_W-1:0] m_fallthru,
    input  logic              w_ret,
    input  logic [ADDR_W-1:0] w_retaddr,
    output logic [ADDR_W-1:0] fetch_pc,
    output logic [ADDR_W-1:0] pred_pc,
    output logic              dec_bubble,
    output logic              exe_bubble,
    output logic              fetch_stall
);
    logic              mispred;
    logic [ADDR_W-1:0] guess;

    fpc_hazard u_hazard (
        .rst_n       (rst_n),
        .d_ret       (d_ret),
        .e_ret       (e_ret),
        .m_ret       (m_ret),
        .m_cjump     (m_cjump),
        .m_taken     (m_taken),
        .mispred     (mispred),
        .dec_bubble  (dec_bubble),
        .exe_bubble  (exe_bubble),
        .fetch_stall (fetch_stall)
    );

    fpc_select #(.ADDR_W(ADDR_W)) u_select (
        .mispred  (mispred),
        .fall_pc  (m_fallthru),
        .ret_wb   (w_ret),
        .ret_pc   (w_retaddr),
        .pred     (pred_pc),
        .fetch_pc (fetch_pc)
    );

    fpc_predict #(.ADDR_W(ADDR_W)) u_predict (
        .cls     (f_cls),
        .nextseq (f_nextseq),
        .target  (f_target),
        .guess   (guess)
    );

    // Predicted-PC register: clear on reset, hold while stalled, else load the guess.
    always_ff @(posedge clk) begin
        if (!rst_n)            pred_pc <= '0;
        else if (!fetch_stall) pred_pc <= guess;
    end
endmodule

// File: rtl/fpc_checker.sv
// Property checker for fetch_pc_ctrl, attached with bind below.
// Observes ports only.
module fpc_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        f_cls,
    input logic [ADDR_W-1:0] f_nextseq,
    input logic [ADDR_W-1:0] f_target,
    input logic              d_ret,
    input logic              e_ret,
    input logic              m_ret,
    input logic              m_cjump,
    input logic              m_taken,
    input logic [ADDR_W-1:0] m_fallthru,
    input logic              w_ret,
    input logic [ADDR_W-1:0] w_retaddr,
    input logic [ADDR_W-1:0] fetch_pc,
    input logic [ADDR_W-1:0] pred_pc,
    input logic              dec_bubble,
    input logic              exe_bubble,
    input logic              fetch_stall
);
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |-> (!dec_bubble && !exe_bubble && !fetch_stall)); // R1
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (pred_pc == '0)); // R1
    AST_PLAIN_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch_stall && f_cls == 3'd0) |=> (pred_pc == $past(f_nextseq))); // R2
    AST_XFER_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch_stall && (f_cls == 3'd1 || f_cls == 3'd2 || f_cls == 3'd3))
        |=> (pred_pc == $past(f_target))); // R4
    AST_MISPRED_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        (m_cjump && !m_taken) |-> (fetch_pc == m_fallthru)); // R5
    AST_MISPRED_SQUASH: assert property (@(posedge clk) disable iff (!rst_n)
        (m_cjump && !m_taken) |-> (dec_bubble && exe_bubble && !fetch_stall)); // R6
    AST_RET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((d_ret || e_ret || m_ret) && !(m_cjump && !m_taken)) |=> $stable(pred_pc)); // R7
    AST_RET_WB: assert property (@(posedge clk) disable iff (!rst_n)
        (w_ret && !(m_cjump && !m_taken)) |-> (fetch_pc == w_retaddr)); // R8
    AST_TAKEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (m_cjump && m_taken && !d_ret && !e_ret && !m_ret)
        |-> (!dec_bubble && !exe_bubble && !fetch_stall)); // R10
endmodule

bind fetch_pc_ctrl fpc_checker #(.ADDR_W(ADDR_W)) u_fpc_checker (.*);

// File: tb/test_fetch_pc_ctrl.sv
// Scoreboard bench: the driver computes expected outputs from the requirements and
// queues them; the monitor pops one entry each falling edge and compares.
module test_fetch_pc_ctrl;
    localparam int AW = 32;
    localparam int PER = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    f_cls = '0;
    logic [AW-1:0] f_nextseq = '0, f_target = '0;
    logic          d_ret = 0, e_ret = 0, m_ret = 0, m_cjump = 0, m_taken = 0, w_ret = 0;
    logic [AW-1:0] m_fallthru = '0, w_retaddr = '0;
    logic [AW-1:0] fetch_pc, pred_pc;
    logic          dec_bubble, exe_bubble, fetch_stall;

    int checks = 0;
    int fails  = 0;

    logic [AW-1:0] q_fpc[$];
    logic [AW-1:0] q_ppc[$];
    logic [2:0]    q_flg[$];
    string         q_tag[$];
    logic [AW-1:0] ref_pred = '0;

    always #(PER/2) clk = ~clk;

    fetch_pc_ctrl #(.ADDR_W(AW)) i_fetch_pc_ctrl (
        .clk(clk), .rst_n(rst_n), .f_cls(f_cls), .f_nextseq(f_nextseq),
        .f_target(f_target), .d_ret(d_ret), .e_ret(e_ret), .m_ret(m_ret),
        .m_cjump(m_cjump), .m_taken(m_taken), .m_fallthru(m_fallthru),
        .w_ret(w_ret), .w_retaddr(w_retaddr), .fetch_pc(fetch_pc),
        .pred_pc(pred_pc), .dec_bubble(dec_bubble), .exe_bubble(exe_bubble),
        .fetch_stall(fetch_stall)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Driver: apply one cycle of stimulus, queue the expected outputs, advance the model.
    task automatic step(input bit rs, input logic [2:0] cls, input logic [AW-1:0] tgt,
                        input bit dr, input bit er, input bit mr,
                        input bit cj, input bit tk, input logic [AW-1:0] va,
                        input bit wr, input logic [AW-1:0] wv, input string tag);
        logic [AW-1:0] efetch;
        bit mis, st, db, eb;
        @(posedge clk);
        #2;
        mis = rs && cj && !tk;
        st  = rs && (dr || er || mr) && !mis;
        db  = mis || (rs && (dr || er || mr));
        eb  = mis;
        efetch = mis ? va : (wr ? wv : ref_pred);
        rst_n = rs; f_cls = cls; f_target = tgt; f_nextseq = efetch + 6;
        d_ret = dr; e_ret = er; m_ret = mr; m_cjump = cj; m_taken = tk;
        m_fallthru = va; w_ret = wr; w_retaddr = wv;
        q_fpc.push_back(efetch);
        q_ppc.push_back(ref_pred);
        q_flg.push_back({db, eb, st});
        q_tag.push_back(tag);
        if (!rs) ref_pred = '0;
        else if (!st) ref_pred = (cls == 3'd1 || cls == 3'd2 || cls == 3'd3) ? tgt : efetch + 6;
    endtask

    // Monitor: compare the design outputs against the oldest scoreboard entry.
    always @(negedge clk) begin
        if (q_fpc.size() > 0) begin
            logic [AW-1:0] ef, ep;
            logic [2:0] fl;
            string t;
            ef = q_fpc.pop_front(); ep = q_ppc.pop_front();
            fl = q_flg.pop_front(); t = q_tag.pop_front();
            chk(fetch_pc == ef, t, "fetch_pc", fetch_pc, ef);
            chk(pred_pc == ep, t, "pred_pc", pred_pc, ep);
            chk(dec_bubble == fl[2], t, "dec_bubble", AW'(dec_bubble), AW'(fl[2]));
            chk(exe_bubble == fl[1], t, "exe_bubble", AW'(exe_bubble), AW'(fl[1]));
            chk(fetch_stall == fl[0], t, "fetch_stall", AW'(fetch_stall), AW'(fl[0]));
        end
    end

    initial begin
        #(PER * 200000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R1: reset with a mispredict and a return pending on the inputs
        step(0, 3'd0, 0, 1, 0, 0, 1, 0, 32'h55, 0, 0, "R1");
        step(0, 3'd3, 32'h99, 0, 1, 0, 1, 0, 32'h55, 0, 0, "R1");
        step(0, 3'd0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R1");
        // R2: straight-line code from 0
        step(1, 3'd0, 32'h700, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
        step(1, 3'd0, 32'h700, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
        step(1, 3'd7, 32'h700, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
        step(1, 3'd0, 32'h700, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
        // R3: jump then call
        step(1, 3'd1, 32'h40, 0, 0, 0, 0, 0, 0, 0, 0, "R3");
        step(1, 3'd2, 32'h80, 0, 0, 0, 0, 0, 0, 0, 0, "R3");
        // R4 and R10: conditional jump guessed taken, resolved taken
        step(1, 3'd3, 32'hA0, 0, 0, 0, 0, 0, 0, 0, 0, "R4");
        step(1, 3'd0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R4");
        step(1, 3'd0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R4");
        step(1, 3'd0, 0, 0, 0, 0, 1, 1, 32'h86, 0, 0, "R10");
        // R5 and R6: conditional jump at 0xB2 guessed taken, resolved not taken
        step(1, 3'd3, 32'h200, 0, 0, 0, 0, 0, 0, 0, 0, "R4");
        step(1, 3'd0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R5");
        step(1, 3'd0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R5");
        step(1, 3'd0, 0, 0, 0, 0, 1, 0, 32'hB8, 0, 0, "R5_R6");
        // R7 and R8: return at 0xBE passes decode, execute, memory, write-back
        step(1, 3'd4, 32'h777, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
        step(1, 3'd0, 32'h777, 1, 0, 0, 0, 0, 0, 0, 0, "R7");
        step(1, 3'd1, 32'h777, 0, 1, 0, 0, 0, 0, 0, 0, "R7");
        step(1, 3'd0, 32'h777, 0, 0, 1, 0, 0, 0, 0, 0, "R7");
        step(1, 3'd0, 0, 0, 0, 0, 0, 0, 0, 1, 32'h300, "R8");
        step(1, 3'd0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R8");
        // R9: mispredict beats write-back return, which beats prediction
        step(1, 3'd0, 0, 0, 0, 0, 1, 0, 32'h400, 1, 32'h500, "R9");
        step(1, 3'd0, 0, 0, 0, 0, 0, 0, 32'h400, 1, 32'h600, "R9");
        // R6: mispredict squashes a wrong-path return in decode, no stall
        step(1, 3'd0, 0, 1, 0, 0, 1, 0, 32'h800, 0, 0, "R6");
        step(1, 3'd0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
        // R1: reset again mid-run
        step(0, 3'd1, 32'h900, 0, 1, 0, 0, 0, 0, 0, 0, "R1");
        step(1, 3'd0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R1");
        @(posedge clk);
        @(negedge clk);
        #1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule